// File: doc/BRIEF.md
# Synchronous Burst Reader with Suspend

This block reads a run of consecutive words out of an on-chip array in clocked burst form, the way a synchronous flash part feeds a host. A host selects the block, presents a start address and marks it with an address strobe. After a fixed number of clock edges of initial latency the block puts one word per clock edge on its data output. A ready-style WAIT output stays high until the first valid word is on the outputs. The array is filled through a simple synchronous write port.

The host can freeze a burst at any point by halting the clock and releasing output enable, so that another device can use the shared bus. A halted clock is modelled by a clock-enable input. The latency counter, the address counter and the output word all hold while the clock is halted. The array read keeps running on the free clock, so the word the burst will need next is already sensed when it resumes. Once the clock is re-enabled, the burst continues from the word where it stopped. The data drive enable follows chip select and output enable. The WAIT drive enable follows chip select alone, so WAIT is still driven during a suspend.

A start address can be taken in two ways. One is a clock edge at which the strobe is high. The other is the end of a strobe that was held while the clock was halted.

Top module: `sbr_burst_reader`

## Requirements
- R1: After a synchronous reset, `wait_o` is 1 and `data_o` is 0.
- R2: An edge with `chip_sel`, `addr_load` and `clk_en` all high starts a new burst at `addr_in`. This also holds in the middle of a running burst, which is then abandoned.
- R3: If `addr_load` was high at one edge and is low at the next, and no clocked start (R2) happened during that strobe, the next edge starts a burst at the last address seen while the strobe was high. This happens even when `clk_en` is low.
- R4: The first word appears on `data_o` at the LAT-th edge with `clk_en` high after the start edge. `wait_o` is 1 from the start edge until that word appears and 0 while a word is valid.
- R5: A burst delivers BLEN words from consecutive addresses, incrementing linearly modulo the array size, one per enabled edge. At the next enabled edge `wait_o` returns to 1 and `data_o` keeps the last word.
- R6: At an edge with `clk_en` low and no new start, `data_o`, `wait_o` and the burst position do not change.
- R7: A suspend during the initial latency leaves the number of enabled edges before the first word unchanged.
- R8: A suspend after words have appeared holds the last word, and the burst resumes with the following address at the first enabled edge.
- R9: Array sensing continues while the clock is halted. A word written into the array before the burst reaches it is the word delivered.
- R10: `data_oe_o` is high exactly when `chip_sel` and `out_en` are both high. It is therefore low during a suspend.
- R11: `wait_drv_o` equals `chip_sel` and is unaffected by `out_en` and `clk_en`. It stays high during a suspend.
- R12: An edge with `chip_sel` low ends any burst: `wait_o` becomes 1, and no word appears until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | High: host clock running; low: host clock halted |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| addr_load | input | 1 | Address strobe, active high |
| addr_in | input | AW | Burst start address |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write address |
| wr_data | input | DW | Array write data |
| data_o | output | DW | Current burst word |
| data_oe_o | output | 1 | Drive enable for `data_o`; low means high impedance |
| wait_o | output | 1 | High while no valid word is presented |
| wait_drv_o | output | 1 | Drive enable for `wait_o` |

## Verification
The bench goes after suspends placed at different points. One comes one edge into the latency: a design that let the latency counter run on the free clock would deliver the first word early. Another falls mid-burst: a design that kept stepping the address would skip or repeat a word on resume. A strobe released while the clock is halted must still start a burst; a design that latched only on clocked edges would never leave WAIT. Other cases are a burst that crosses the top of the address space, a restart and a deselect in mid-burst, a word rewritten just before its burst, and a pseudo-random clock-enable pattern. A wrong counter reset or end-of-burst test in any of these shows up as a word mismatch or WAIT on the wrong edge.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LAT   = 2'd1,
    PH_BURST = 2'd2
  } phase_t;
endpackage

// File: rtl/sbr_array.sv
module sbr_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // sensing runs on the free clock, independent of the host clock enable
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sbr_addr_capture.sv
module sbr_addr_capture #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel,
  input  logic          clk_en,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  output logic          start_o,
  output logic [AW-1:0] start_addr_o
);
  logic          strobe_q;
  logic          used_q;
  logic [AW-1:0] hold_q;
  logic          clk_start;
  logic          rel_start;

  assign clk_start    = chip_sel & addr_load & clk_en;
  assign rel_start    = chip_sel & strobe_q & ~addr_load & ~used_q;
  assign start_o      = clk_start | rel_start;
  assign start_addr_o = clk_start ? addr_in : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      used_q   <= 1'b0;
      hold_q   <= '0;
    end else begin
      strobe_q <= addr_load;
      if (addr_load) hold_q <= addr_in;
      if (!addr_load)     used_q <= 1'b0;
      else if (clk_start) used_q <= 1'b1;
    end
  end

  // R3: a strobe already consumed by a clocked start must not start again on release
  assert_no_double_start_R3: assert property (@(posedge clk) disable iff (rst)
    clk_start |=> !rel_start);

  // R3: a release start only follows a strobe seen at the previous edge
  assert_release_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    rel_start |-> $past(addr_load));
endmodule

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq
  import sbr_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int LAT  = 4,
  parameter int BLEN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel,
  input  logic          clk_en,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] sense_data,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] data_o,
  output logic          wait_o
);
  localparam int LW = $clog2(LAT + 1);
  localparam int CW = $clog2(BLEN + 1);

  phase_t        phase_q, phase_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] lat_q, lat_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] data_q, data_d;
  logic          wait_q;

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    lat_d   = lat_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    if (!chip_sel) begin
      phase_d = PH_IDLE;
    end else if (start) begin
      phase_d = PH_LAT;
      addr_d  = start_addr;
      lat_d   = LW'(LAT);
      cnt_d   = '0;
    end else if (clk_en) begin
      case (phase_q)
        PH_LAT: begin
          if (lat_q == LW'(1)) begin
            phase_d = PH_BURST;
            data_d  = sense_data;
            addr_d  = addr_q + 1'b1;
            cnt_d   = CW'(1);
          end else begin
            lat_d = lat_q - 1'b1;
          end
        end
        PH_BURST: begin
          if (cnt_q == CW'(BLEN)) begin
            phase_d = PH_IDLE;
          end else begin
            data_d = sense_data;
            addr_d = addr_q + 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // the array always senses the word the burst will present next
  assign rd_addr = addr_d;
  assign data_o  = data_q;
  assign wait_o  = wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      lat_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      wait_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      lat_q   <= lat_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      wait_q  <= (phase_d != PH_BURST);
    end
  end

  // R6: a halted clock freezes position and output
  assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && !clk_en && !start) |=>
      ($stable(addr_q) && $stable(lat_q) && $stable(cnt_q) && $stable(data_q) && $stable(wait_q)));

  // R4: WAIT is raised by a start
  assert_wait_after_start_R4: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && start) |=> wait_q);

  // R4: latency count stays in range while waiting
  assert_lat_range_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LAT) |-> (lat_q >= LW'(1) && lat_q <= LW'(LAT)));

  // R5: each delivered word steps the address by one
  assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && !start && clk_en && phase_q == PH_BURST && cnt_q != CW'(BLEN)) |=>
      (addr_q == AW'($past(addr_q) + 1'b1)));

  // R5: never more than BLEN words
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(BLEN));

  // R12: deselect ends the burst
  assert_deselect_R12: assert property (@(posedge clk) disable iff (rst)
    !chip_sel |=> (wait_q && phase_q == PH_IDLE));
endmodule

// File: rtl/sbr_burst_reader.sv
module sbr_burst_reader #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int LAT  = 4,
  parameter int BLEN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          chip_sel,
  input  logic          out_en,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wait_o,
  output logic          wait_drv_o
);
  logic          start;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] sense_data;

  sbr_addr_capture #(.AW(AW)) u_capture (
    .clk          (clk),
    .rst          (rst),
    .chip_sel     (chip_sel),
    .clk_en       (clk_en),
    .addr_load    (addr_load),
    .addr_in      (addr_in),
    .start_o      (start),
    .start_addr_o (start_addr)
  );

  sbr_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (sense_data)
  );

  sbr_burst_seq #(.AW(AW), .DW(DW), .LAT(LAT), .BLEN(BLEN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .chip_sel   (chip_sel),
    .clk_en     (clk_en),
    .start      (start),
    .start_addr (start_addr),
    .sense_data (sense_data),
    .rd_addr    (rd_addr),
    .data_o     (data_o),
    .wait_o     (wait_o)
  );

  // output drive gating: data by select and output enable, WAIT by select only
  assign data_oe_o  = chip_sel & out_en;
  assign wait_drv_o = chip_sel;
endmodule

// File: tb/sbr_burst_reader_bench.sv
module sbr_burst_reader_bench;
  localparam int AW   = 8;
  localparam int DW   = 16;
  localparam int LAT  = 4;
  localparam int BLEN = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b1;
  logic          chip_sel = 1'b0;
  logic          out_en = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          wait_o;
  logic          wait_drv_o;

  sbr_burst_reader #(.AW(AW), .DW(DW), .LAT(LAT), .BLEN(BLEN)) u_sbr_burst_reader (
    .clk(clk), .rst(rst), .clk_en(clk_en), .chip_sel(chip_sel), .out_en(out_en),
    .addr_load(addr_load), .addr_in(addr_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .data_o(data_o), .data_oe_o(data_oe_o), .wait_o(wait_o),
    .wait_drv_o(wait_drv_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string tag = "R1";

  // behavioural reference model
  logic [DW-1:0] mem_m [DEPTH];
  int            m_phase = 0;   // 0 idle, 1 latency, 2 delivering
  int            m_lat = 0;
  int            m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic          m_wait = 1'b1;
  logic          m_sq = 1'b0;
  logic          m_used = 1'b0;
  logic [AW-1:0] m_hold = '0;
  logic          m_ready = 1'b0;
  logic          m_cl, m_rl;
  logic [AW-1:0] m_la;

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 40503 + 4660) ^ (i << 7));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_phase = 0; m_lat = 0; m_cnt = 0; m_addr = '0; m_data = '0; m_wait = 1'b1;
      m_sq = 1'b0; m_used = 1'b0; m_hold = '0; m_ready = 1'b1;
    end else begin
      m_cl = chip_sel && addr_load && clk_en;
      m_rl = chip_sel && m_sq && !addr_load && !m_used;
      m_la = m_cl ? addr_in : m_hold;
      if (!chip_sel) begin
        m_phase = 0;
      end else if (m_cl || m_rl) begin
        m_phase = 1; m_addr = m_la; m_lat = LAT; m_cnt = 0;
      end else if (clk_en) begin
        if (m_phase == 1) begin
          m_lat--;
          if (m_lat == 0) begin
            m_phase = 2; m_data = mem_m[m_addr]; m_addr++; m_cnt = 1;
          end
        end else if (m_phase == 2) begin
          if (m_cnt == BLEN) m_phase = 0;
          else begin m_data = mem_m[m_addr]; m_addr++; m_cnt++; end
        end
      end
      m_wait = (m_phase != 2);
      if (addr_load) m_hold = addr_in;
      if (!addr_load) m_used = 1'b0; else if (m_cl) m_used = 1'b1;
      m_sq = addr_load;
      if (wr_en) mem_m[wr_addr] = wr_data;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // wait for the falling edge, compare against the model, then caller drives
  task automatic nxt();
    @(negedge clk);
    if (m_ready && !rst) begin
      chk({tag, " data"}, 32'(data_o), 32'(m_data));
      chk({tag, " wait"}, 32'(wait_o), 32'(m_wait));
      chk({tag, " data_oe R10"}, 32'(data_oe_o), 32'(chip_sel && out_en));
      chk({tag, " wait_drv R11"}, 32'(wait_drv_o), 32'(chip_sel));
    end
  endtask

  task automatic clk_start(logic [AW-1:0] a);
    addr_load = 1'b1; addr_in = a; clk_en = 1'b1;
    nxt();
    addr_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    wait (cycles > 50000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end

  initial begin : stim
    int n;
    logic [15:0] lf;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nxt();
    tag = "R1";
    chk("R1 reset wait", 32'(wait_o), 32'd1);
    chk("R1 reset data", 32'(data_o), 32'd0);

    // preload the array
    wr_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = AW'(i); wr_data = pat(i);
      nxt();
    end
    wr_en = 1'b0;
    chip_sel = 1'b1; out_en = 1'b1;
    nxt();

    // R2 + R4: clocked start, latency count
    tag = "R2";
    clk_start(8'h10);
    n = 0;
    while (wait_o && n < 20) begin nxt(); n++; end
    chk("R4 latency edges", 32'(n), 32'(LAT));
    chk("R2 first word", 32'(data_o), 32'(pat(16)));
    tag = "R5";
    repeat (BLEN + 2) nxt();
    chk("R5 wait after burst", 32'(wait_o), 32'd1);
    chk("R5 last word held", 32'(data_o), 32'(pat(16 + BLEN - 1)));

    // R5: crossing the top of the address space
    clk_start(8'hFC);
    repeat (LAT + 5) nxt();
    chk("R5 wrap word", 32'(data_o), 32'(pat(1)));
    repeat (BLEN) nxt();

    // R3: strobe released while the clock is halted
    tag = "R3";
    clk_en = 1'b0; addr_load = 1'b1; addr_in = 8'h40;
    nxt(); nxt();
    addr_in = 8'h77; addr_load = 1'b0;
    nxt();
    repeat (3) nxt();
    chk("R3 wait while halted", 32'(wait_o), 32'd1);
    clk_en = 1'b1;
    repeat (LAT) nxt();
    chk("R3 word from released strobe", 32'(data_o), 32'(pat(8'h40)));
    repeat (BLEN + 1) nxt();

    // R7: suspend one edge into the latency
    tag = "R7";
    clk_start(8'h30);
    nxt();
    clk_en = 1'b0; out_en = 1'b0;
    repeat (6) nxt();
    chk("R10 oe off in suspend", 32'(data_oe_o), 32'd0);
    chk("R11 wait driven in suspend", 32'(wait_drv_o), 32'd1);
    chk("R7 wait held in suspend", 32'(wait_o), 32'd1);
    out_en = 1'b1; clk_en = 1'b1;
    repeat (LAT - 2) nxt();
    chk("R7 still waiting", 32'(wait_o), 32'd1);
    nxt();
    chk("R7 first word after resume", 32'(data_o), 32'(pat(8'h30)));

    // R8: suspend mid-burst
    tag = "R8";
    nxt(); nxt();
    held = data_o;
    chk("R8 third word", 32'(held), 32'(pat(8'h32)));
    clk_en = 1'b0; out_en = 1'b0;
    repeat (5) nxt();
    chk("R8 word retained", 32'(data_o), 32'(held));
    chk("R6 wait frozen", 32'(wait_o), 32'd0);
    out_en = 1'b1; clk_en = 1'b1;
    nxt();
    chk("R8 resume next word", 32'(data_o), 32'(pat(8'h33)));
    repeat (BLEN) nxt();

    // R9: word rewritten before the burst reaches it, with a halt in between
    tag = "R9";
    wr_en = 1'b1; wr_addr = 8'h22; wr_data = 16'hBEEF;
    nxt();
    wr_en = 1'b0;
    clk_start(8'h20);
    clk_en = 1'b0;
    repeat (4) nxt();
    clk_en = 1'b1;
    repeat (LAT + 2) nxt();
    chk("R9 rewritten word", 32'(data_o), 32'h0000BEEF);
    repeat (BLEN) nxt();

    // R12: deselect mid-burst
    tag = "R12";
    clk_start(8'h50);
    repeat (LAT + 2) nxt();
    chip_sel = 1'b0;
    nxt();
    chk("R11 wait not driven", 32'(wait_drv_o), 32'd0);
    chip_sel = 1'b1;
    repeat (3) nxt();
    chk("R12 no burst after deselect", 32'(wait_o), 32'd1);

    // R2: restart in mid-burst
    tag = "R2";
    clk_start(8'h60);
    repeat (LAT + 3) nxt();
    clk_start(8'h90);
    repeat (LAT) nxt();
    chk("R2 restart word", 32'(data_o), 32'(pat(8'h90)));
    repeat (BLEN) nxt();

    // R6: pseudo-random clock enable and output enable
    tag = "R6";
    lf = 16'hACE1;
    for (int b = 0; b < 12; b++) begin
      clk_start(AW'(b * 19));
      for (int k = 0; k < 40; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        clk_en = lf[0] | lf[3];
        out_en = lf[5] | clk_en;
        nxt();
      end
    end
    clk_en = 1'b1; out_en = 1'b1;
    repeat (4) nxt();
    finish_run();
  end
endmodule